// File: doc/BRIEF.md
# Programmable Divider with Selectable Reload Policy

This block divides a stream of input edges, such as a reference clock or the output of a dual-modulus prescaler on the oscillator path, by a programmable 11-bit ratio. It produces a terminal-count signal for a phase comparator and also exposes the current count. All logic runs on a system clock `clk`. The divided signal `sig_in` is sampled on that clock, and the counter moves down by one on each rising edge that is seen.

A new ratio arrives on `wr_val` together with a one-cycle strobe `wr_stb`. The level of `force_mode` at that strobe sets how the value takes effect.

- **Synchronous reload:** the value waits in a shadow register and is loaded only when the count wraps through zero, so the running period is never cut short.
- **Forced reload:** the counter restarts at once from the new value, which shortens settling after a band change.

An active-low `pwr_n` parks the counter at its reload value and silences the output.

The control state machine has two states:

- **ST_COUNT:** normal division.
- **ST_HALT:** powered down.

It has two transitions:

- **PWR_DOWN:** from ST_COUNT to ST_HALT, taken at the clock edge where `pwr_n` is low.
- **WAKE:** from ST_HALT to ST_COUNT, taken at the clock edge where `pwr_n` is high.

Top module: `div_reload_counter`

## Requirements
- R1: After reset the state is ST_COUNT, `count_o` equals RST_DIV-1 (15 by default), `tc_o` is low and no value is pending.
- R2: In ST_COUNT, a rising edge is seen at a clock edge where `sig_in` is 1 and was 0 at the previous clock edge. At each such edge `count_o` drops by one unless it is 0. Without a rising edge and without a write, `count_o` holds.
- R3: `tc_o` is high exactly while the state is ST_COUNT and `count_o` is 0. It therefore lasts one input period and recurs every N input edges, where N is the active ratio.
- R4: A rising edge while `count_o` is 0 reloads `count_o` with N-1. N comes from the pending value if one exists and otherwise from the active value. The value used becomes active and the pending flag clears.
- R5: A write with `force_mode`=0 in ST_COUNT only stores a pending value, which replaces any earlier pending value. `count_o` keeps its sequence until the next reload. A write in the same cycle as a reload is kept for the reload after that one.
- R6: A write with `force_mode`=1 in ST_COUNT sets `count_o` to N-1 at the next clock edge, where N is the written value. That value becomes active, any pending value is dropped, and the write takes priority over a rising edge in the same cycle.
- R7: A programmed value of 0 or 1 acts as a ratio of 2.
- R8: PWR_DOWN is taken at the clock edge where `pwr_n` is low. In ST_HALT, `tc_o` is low, input edges are ignored, and `count_o` is set each cycle to the reload value of the latest value. That latest value is the write in that cycle if there is one, otherwise the pending value, otherwise the active value. In ST_HALT a write takes effect immediately in either mode.
- R9: WAKE is taken at the clock edge where `pwr_n` is high, and counting then resumes down from the held reload value.
- R10: The largest value, 2047, divides by 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low powerdown |
| sig_in | input | 1 | Input edge stream to divide |
| wr_stb | input | 1 | One-cycle strobe for a new ratio |
| wr_val | input | CW (11) | New ratio value |
| force_mode | input | 1 | 1 = forced reload, 0 = synchronous reload |
| tc_o | output | 1 | Terminal-count signal for the phase comparator |
| count_o | output | CW (11) | Current count |

## Verification
The assertions assume that `sig_in` changes only between clock edges and stays at each level for at least one clock, so each rising edge is seen exactly once. They also assume that `wr_stb`, `wr_val` and `force_mode` are valid at every clock edge after reset. The stimulus drives every input on the falling clock edge, holds `sig_in` high for one clock and low for at least one clock, and pulses `wr_stb` for a single cycle. It places writes in the middle of a count, on the reload edge itself, and during powerdown.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_HALT  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_edge_det.sv
module div_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/div_shadow.sv
module div_shadow #(
    parameter int CW      = 11,
    parameter int RST_VAL = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [CW-1:0] wr_val,
    input  logic          direct,   // write goes straight to the active value
    input  logic          take,     // adopt the pending value, if any
    output logic [CW-1:0] rl_val    // value a reload would use now
);
    logic [CW-1:0] act_q;
    logic [CW-1:0] pend_q;
    logic          pflag_q;

    assign rl_val = pflag_q ? pend_q : act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= CW'(RST_VAL);
            pend_q  <= '0;
            pflag_q <= 1'b0;
        end else if (wr_stb && direct) begin
            act_q   <= wr_val;
            pflag_q <= 1'b0;
        end else if (wr_stb) begin
            if (take) act_q <= rl_val;
            pend_q  <= wr_val;
            pflag_q <= 1'b1;
        end else if (take) begin
            act_q   <= rl_val;
            pflag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/div_reload_counter.sv
module div_reload_counter
    import div_pkg::*;
#(
    parameter int CW      = 11,
    parameter int RST_DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_n,
    input  logic          sig_in,
    input  logic          wr_stb,
    input  logic [CW-1:0] wr_val,
    input  logic          force_mode,
    output logic          tc_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

    // Reload count for a value: ratio-1, with a ratio floor of 2.
    function automatic logic [CW-1:0] reload_of(input logic [CW-1:0] v);
        return (v < CW'(2)) ? CW'(1) : v - CW'(1);
    endfunction

    div_state_e    state_q, state_d;
    logic [CW-1:0] count_q;
    logic          rise;
    logic [CW-1:0] rl_val;
    logic          halted, wrap, forced;

    div_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_in),
        .rise_o (rise)
    );

    assign halted = (state_q == ST_HALT);
    assign forced = wr_stb && force_mode && !halted;
    assign wrap   = !halted && rise && (count_q == '0) && !forced;

    div_shadow #(.CW(CW), .RST_VAL(RST_DIV)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wr_val (wr_val),
        .direct (force_mode || halted),
        .take   (halted || wrap),
        .rl_val (rl_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (!pwr_n) state_d = ST_HALT;   // PWR_DOWN
            ST_HALT:  if (pwr_n)  state_d = ST_COUNT;  // WAKE
            default:  state_d = ST_COUNT;
        endcase
    end

    // Outputs
    always_comb begin
        tc_o = 1'b0;
        unique case (state_q)
            ST_COUNT: tc_o = (count_q == '0);
            ST_HALT:  tc_o = 1'b0;
            default:  tc_o = 1'b0;
        endcase
    end

    // Counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= reload_of(CW'(RST_DIV));
        end else if (halted) begin
            count_q <= reload_of(wr_stb ? wr_val : rl_val);
        end else if (forced) begin
            count_q <= reload_of(wr_val);
        end else if (rise) begin
            count_q <= (count_q == '0) ? reload_of(rl_val) : count_q - CW'(1);
        end
    end

    assign count_o = count_q;

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && rise && count_q != '0 && !(wr_stb && force_mode))
        |=> count_q == $past(count_q) - CW'(1));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !rise && !wr_stb) |=> $stable(count_q));

    // R6
    force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && wr_stb && force_mode)
        |=> count_q == (($past(wr_val) < CW'(2)) ? CW'(1) : $past(wr_val) - CW'(1)));

    // R7
    min_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && rise && count_q == '0) |=> count_q != '0);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !tc_o);

    // R10
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q != ALL_ONES);
endmodule

// File: tb/div_reload_counter_tb.sv
module div_reload_counter_tb;
    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_n = 1'b1;
    logic          sig_in = 1'b0;
    logic          wr_stb = 1'b0;
    logic [CW-1:0] wr_val = '0;
    logic          force_mode = 1'b0;
    logic          tc_o;
    logic [CW-1:0] count_o;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_count, m_act, m_pend;
    bit m_pflag, m_halt, m_sigq;

    always #5 clk = ~clk;

    div_reload_counter #(.CW(CW), .RST_DIV(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .sig_in(sig_in),
        .wr_stb(wr_stb), .wr_val(wr_val), .force_mode(force_mode),
        .tc_o(tc_o), .count_o(count_o)
    );

    function automatic int rl(input int v);
        return (v < 2) ? 1 : v - 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_count = 15; m_act = 16; m_pend = 0;
            m_pflag = 0; m_halt = 0; m_sigq = 0;
        end else begin
            bit ed;
            int v;
            ed = sig_in && !m_sigq;
            m_sigq = sig_in;
            v = int'(wr_val);
            if (m_halt) begin
                if (wr_stb) m_act = v;
                else if (m_pflag) m_act = m_pend;
                m_pflag = 0;
                m_count = rl(m_act);
            end else if (wr_stb && force_mode) begin
                m_act = v; m_pflag = 0; m_count = rl(v);
            end else begin
                if (ed && m_count == 0) begin
                    if (m_pflag) m_act = m_pend;
                    m_pflag = 0;
                    m_count = rl(m_act);
                end else if (ed) begin
                    m_count = m_count - 1;
                end
                if (wr_stb) begin m_pend = v; m_pflag = 1; end
            end
            m_halt = !pwr_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit etc;
            etc = !m_halt && (m_count == 0);
            n_vec++;
            if (int'(count_o) != m_count || tc_o != etc) begin
                n_bad++;
                $display("FAIL %s: count=%0d tc=%0b expected count=%0d tc=%0b",
                         cur_req, count_o, tc_o, m_count, etc);
            end
        end
    end

    task automatic step(input bit s, input bit w, input int v, input bit f);
        @(negedge clk);
        sig_in = s; wr_stb = w; wr_val = CW'(v); force_mode = f;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, 0);
            step(0, 0, 0, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, explicit
        n_vec++;
        if (count_o != 11'd15 || tc_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: count=%0d tc=%0b expected count=15 tc=0", count_o, tc_o);
        end
        cur_req = "R2"; edges(10);
        cur_req = "R3"; edges(40);
        cur_req = "R5"; step(0, 1, 5, 0); step(0, 1, 6, 0); edges(30);
        cur_req = "R4"; edges(4);
        cur_req = "R7"; step(0, 1, 1, 0); edges(12);
        step(0, 1, 0, 0); edges(12);
        cur_req = "R6"; step(0, 1, 20, 0); edges(3); step(0, 1, 7, 1); edges(25);
        step(1, 1, 9, 1); step(0, 0, 0, 0); edges(22);
        cur_req = "R5"; // write on the reload edge
        step(0, 1, 4, 1);
        edges(3);
        step(1, 1, 3, 0); step(0, 0, 0, 0); edges(12);
        cur_req = "R8";
        step(0, 1, 12, 0);
        pwr_n = 1'b0;
        edges(5);
        step(0, 1, 9, 0); edges(3);
        step(0, 1, 0, 1); edges(2);
        step(0, 1, 6, 0);
        cur_req = "R9";
        pwr_n = 1'b1;
        edges(20);
        cur_req = "R10"; step(0, 1, 2047, 1); edges(2 * 2047 + 10);
        step(0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule